// File: doc/BRIEF.md
# Refresh Interval Timer

This block sets the pace of DRAM refresh. A free-running prescaler divides the peripheral clock by one of seven power-of-two ratios. Each prescaler tick advances an 8-bit interval counter, and the counter is compared against a programmable constant on every tick. When the tick would bring the counter up to the constant, the counter returns to zero instead and a compare flag is raised. If refresh is enabled, a refresh request is also handed to the memory controller.

The request is a level. It stays high until the controller acknowledges it. Intervals that elapse before the acknowledge are counted, so none are lost. A small register port gives access to the control fields, the counter and the constant.

With a 25 MHz peripheral clock, ratio 8 and a constant of 0x30, the interval is 48 × 8 × 40 ns = 15.36 µs. That is enough for 4096 refreshes every 64 ms.

Top module: `rfsh_timer`

## Requirements
- R1: After a synchronous active-low reset, all registers read 0, rfsh_req is 0 and cmp_flag is 0.
- R2: With clock-select code 000 the prescaler and the counter hold their values, and no match occurs.
- R3: Codes 1 to 6 select divide ratios 2, 8, 32, 128, 512 and 2048, and code 7 selects 4096. A control write that changes the code restarts the prescaler, so the first counter advance comes exactly one ratio period after that write edge.
- R4: On a tick where counter+1 equals the constant, the counter goes to 0 instead of advancing and the compare flag is set. The interval is therefore the constant in ticks, and a constant of 0 gives 256 ticks.
- R5: A match raises rfsh_req only while the enable bit is 1. With the enable bit at 0 the flag is still set.
- R6: rfsh_req stays high until a cycle in which rfsh_ack is sampled high while rfsh_req is high.
- R7: Matches that arrive before an acknowledge are counted, up to 2^PEND_W-1. Each accepted acknowledge retires one of them. A match and an acknowledge in the same cycle leave the count unchanged. An acknowledge while rfsh_req is low has no effect.
- R8: The flag clears only on a control write with bit 7 = 0 that follows a control read which returned the flag as 1. Any control write disarms the clear. Writing bit 7 = 1 has no effect on the flag.
- R9: When a match and a flag-clearing write fall in the same cycle, the flag stays set.
- R10: Register map: address 0 is control (bits 2:0 code, bit 3 enable, bit 7 flag), address 1 is the counter, address 2 is the constant, and address 3 reads 0. A counter write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms the flag clear) |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational from reg_addr |
| rfsh_req | output | 1 | Refresh request level |
| rfsh_ack | input | 1 | Refresh acknowledge from the controller |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
Two pairs of events can land in the same clock edge: a match with a flag-clearing control write, and a match with an acknowledge of the request. The bench times the clearing write, or the acknowledge pulse, to the exact edge on which the match is due; that edge is known from the restart cycle, the ratio and the constant. It then reads the flag back and expects it set. For the acknowledge case it stops the timer and expects exactly one more acknowledge to drop the request.

// File: rtl/rfsh_pkg.sv
// Shared constants and helpers for the refresh interval timer.
// Assumes the register data width is at least 8 bits.
package rfsh_pkg;
    localparam int PRE_W    = 12;   // prescaler width, covers the largest ratio
    localparam int EN_BIT   = 3;
    localparam int FLAG_BIT = 7;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_CNT  = 2'd1,
        RA_CST  = 2'd2,
        RA_NONE = 2'd3
    } rfsh_addr_e;

    // log2 of the divide ratio chosen by a clock-select code (0 = stopped)
    function automatic int div_log2(input logic [2:0] code);
        if (code == 3'd0) return 0;
        if (code == 3'd7) return PRE_W;
        return 2 * int'(code) - 1;
    endfunction
endpackage

// File: rtl/rfsh_prescaler.sv
// Power-of-two prescaler: emits a one-cycle tick every 2^div_log2(cks) cycles.
// Assumes restart is pulsed when the select code changes; code 0 holds it at zero.
module rfsh_prescaler
    import rfsh_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cks,
    input  logic       restart,
    output logic       tick
);
    logic [PW-1:0] presc;
    logic [PW-1:0] mask;
    int            lg;

    // Build the low-bit mask for the selected ratio
    always_comb begin
        lg = div_log2(cks);
        for (int i = 0; i < PW; i++) mask[i] = (i < lg);
    end

    // Free-running divide counter, cleared on restart or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                     presc <= '0;
        else if (restart || cks == 3'd0) presc <= '0;
        else                            presc <= presc + PW'(1);
    end

    assign tick = (cks != 3'd0) && ((presc & mask) == mask);

    AST_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && cks != 3'd1) |=> !tick); // R3
endmodule

// File: rtl/rfsh_counter.sv
// Interval counter: advances on tick, returns to zero when counter+1 meets the constant.
// Assumes a register write may override the count in any cycle.
module rfsh_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt,
    output logic          match
);
    logic [CW-1:0] nxt;

    assign nxt   = cnt + CW'(1);
    assign match = tick && (nxt == cst);

    // Counter update: write first, then match clear, then advance
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (wr_en)  cnt <= wr_data;
        else if (match)  cnt <= '0;
        else if (tick)   cnt <= nxt;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt)); // R2
    AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !wr_en) |=> (cnt == '0)); // R4
endmodule

// File: rtl/rfsh_req_hold.sv
// Holds the refresh request and counts intervals that are not yet acknowledged.
// Assumes ack is honoured only while the request is high.
module rfsh_req_hold #(
    parameter int PEND_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match_en,
    input  logic ack,
    output logic req
);
    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] pend;
    logic              take;

    assign take = req && ack;
    assign req  = (pend != '0);

    // Pending count: increment on match, decrement on accepted ack, saturate
    always_ff @(posedge clk) begin
        if (!rst_n)                                pend <= '0;
        else if (match_en && !take && pend != PMAX) pend <= pend + PEND_W'(1);
        else if (take && !match_en)                pend <= pend - PEND_W'(1);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req); // R6
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(match_en)); // R5
    AST_PEND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == PMAX && !take) |=> (pend == PMAX)); // R7
endmodule

// File: rtl/rfsh_timer.sv
// Refresh interval timer top: register port, compare flag, and the three sub-blocks.
// Assumes CNT_W >= 8 so that the control fields fit in one register word.
module rfsh_timer
    import rfsh_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             rfsh_req,
    input  logic             rfsh_ack,
    output logic             cmp_flag
);
    logic [2:0]       cks;
    logic             en;
    logic             armed;
    logic [CNT_W-1:0] cst;
    logic [CNT_W-1:0] cnt;
    logic             tick, match, restart;
    logic             ctrl_wr, ctrl_rd, cnt_wr, cst_wr;

    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign ctrl_rd = reg_rd && (reg_addr == RA_CTRL);
    assign cnt_wr  = reg_wr && (reg_addr == RA_CNT);
    assign cst_wr  = reg_wr && (reg_addr == RA_CST);
    assign restart = ctrl_wr && (reg_wdata[2:0] != cks);

    // Control and constant registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cks <= 3'd0;
            en  <= 1'b0;
            cst <= '0;
        end else begin
            if (ctrl_wr) begin
                cks <= reg_wdata[2:0];
                en  <= reg_wdata[EN_BIT];
            end
            if (cst_wr) cst <= reg_wdata;
        end
    end

    // Compare flag with read-then-write-zero clear; a match wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (match)
                cmp_flag <= 1'b1;
            else if (ctrl_wr && armed && !reg_wdata[FLAG_BIT])
                cmp_flag <= 1'b0;
            if (ctrl_wr)                 armed <= 1'b0;
            else if (ctrl_rd && cmp_flag) armed <= 1'b1;
        end
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[2:0]      = cks;
                reg_rdata[EN_BIT]   = en;
                reg_rdata[FLAG_BIT] = cmp_flag;
            end
            RA_CNT:  reg_rdata = cnt;
            RA_CST:  reg_rdata = cst;
            default: reg_rdata = '0;
        endcase
    end

    rfsh_prescaler #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .cks(cks), .restart(restart), .tick(tick)
    );

    rfsh_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cst(cst),
        .wr_en(cnt_wr), .wr_data(reg_wdata), .cnt(cnt), .match(match)
    );

    rfsh_req_hold #(.PEND_W(PEND_W)) u_req (
        .clk(clk), .rst_n(rst_n), .match_en(match && en),
        .ack(rfsh_ack), .req(rfsh_req)
    );

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag); // R9
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(match)); // R4
endmodule

// File: tb/tb_rfsh_timer.sv
// Directed bench for the refresh interval timer; one task per scenario.
module tb_rfsh_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rfsh_req;
    logic       rfsh_ack = 1'b0;
    logic       cmp_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    rfsh_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rfsh_req(rfsh_req), .rfsh_ack(rfsh_ack), .cmp_flag(cmp_flag)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1; #1; d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic ack_pulse();
        rfsh_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        rfsh_ack = 1'b0;
    endtask

    task automatic wait_req(input int lim, output int n);
        n = 0;
        while (!rfsh_req && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(rfsh_req == 0, "R1 req", rfsh_req, 0);
        check(cmp_flag == 0, "R1 flag", cmp_flag, 0);
        for (int a = 0; a < 3; a++) begin
            peek(2'(a), d);
            check(d == 0, "R1 reg", d, 0);
        end
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(2'd2, 8'h5A); peek(2'd2, d); check(d == 8'h5A, "R10 constant", d, 8'h5A);
        wr(2'd1, 8'h33); peek(2'd1, d); check(d == 8'h33, "R10 counter", d, 8'h33);
        peek(2'd3, d); check(d == 0, "R10 unused", d, 0);
        repeat (40) @(negedge clk);
        peek(2'd1, d); check(d == 8'h33, "R2 stopped hold", d, 8'h33);
    endtask

    task automatic t_period();
        logic [7:0] d;
        int n;
        wr(2'd1, 8'd0); wr(2'd2, 8'd4); wr(2'd0, 8'h09);
        wait_req(1000, n);
        check(n == 8, "R3 R5 first request", n, 8);
        peek(2'd1, d); check(d == 0, "R4 counter zero", d, 0);
        check(cmp_flag == 1, "R4 flag set", cmp_flag, 1);
        repeat (3) @(negedge clk);
        check(rfsh_req == 1, "R6 held", rfsh_req, 1);
        ack_pulse();
        check(rfsh_req == 0, "R6 released", rfsh_req, 0);
        wr(2'd0, 8'h88);
        peek(2'd1, d);
        repeat (40) @(negedge clk);
        begin
            logic [7:0] d2;
            peek(2'd1, d2); check(d2 == d, "R2 stop", d2, d);
        end
    endtask

    task automatic t_pending();
        wr(2'd1, 8'd0); wr(2'd0, 8'h89);
        repeat (17) @(negedge clk);
        wr(2'd0, 8'h88);
        ack_pulse(); check(rfsh_req == 1, "R7 second pending", rfsh_req, 1);
        ack_pulse(); check(rfsh_req == 0, "R7 drained", rfsh_req, 0);
        ack_pulse(); check(rfsh_req == 0, "R7 idle ack", rfsh_req, 0);
    endtask

    task automatic t_ack_collide();
        int n;
        wr(2'd1, 8'd0); wr(2'd0, 8'h89);
        wait_req(1000, n);
        repeat (7) @(negedge clk);
        ack_pulse();
        check(rfsh_req == 1, "R7 ack with match", rfsh_req, 1);
        wr(2'd0, 8'h88);
        ack_pulse();
        check(rfsh_req == 0, "R7 count one", rfsh_req, 0);
    endtask

    task automatic t_flag_clear();
        logic [7:0] d;
        rd(2'd0, d); check(d[7] == 1, "R8 read flag", d[7], 1);
        wr(2'd0, 8'h08);
        check(cmp_flag == 0, "R8 cleared", cmp_flag, 0);
    endtask

    task automatic t_disable();
        wr(2'd1, 8'd0); wr(2'd0, 8'h01);
        repeat (20) @(negedge clk);
        check(rfsh_req == 0, "R5 disabled", rfsh_req, 0);
        check(cmp_flag == 1, "R5 flag still set", cmp_flag, 1);
        wr(2'd0, 8'h00);
        check(cmp_flag == 1, "R8 no read no clear", cmp_flag, 1);
    endtask

    task automatic t_ratio(input logic [2:0] code, input logic [7:0] c, input int exp);
        int n;
        wr(2'd0, 8'h88); wr(2'd1, 8'd0); wr(2'd2, c);
        wr(2'd0, 8'h88 | 8'(code));
        wait_req(10000, n);
        check(n == exp, (c == 0) ? "R4 constant zero" : "R3 ratio", n, exp);
        wr(2'd0, 8'h88);
        ack_pulse();
    endtask

    task automatic t_flag_collide();
        logic [7:0] d;
        wr(2'd0, 8'h88); wr(2'd1, 8'd0); wr(2'd2, 8'd4); wr(2'd0, 8'h89);
        rd(2'd0, d);
        repeat (6) @(negedge clk);
        wr(2'd0, 8'h09);
        check(cmp_flag == 1, "R9 set wins", cmp_flag, 1);
        rd(2'd0, d);
        wr(2'd0, 8'h09);
        check(cmp_flag == 0, "R8 clear after reread", cmp_flag, 0);
        wr(2'd0, 8'h88);
        ack_pulse();
        check(rfsh_req == 0, "R6 final release", rfsh_req, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_period();
        t_pending();
        t_ack_collide();
        t_flag_clear();
        t_disable();
        t_ratio(3'd2, 8'd3, 24);
        t_ratio(3'd3, 8'd2, 64);
        t_ratio(3'd4, 8'd1, 128);
        t_ratio(3'd5, 8'd1, 512);
        t_ratio(3'd6, 8'd1, 2048);
        t_ratio(3'd7, 8'd1, 4096);
        t_ratio(3'd1, 8'd0, 512);
        t_flag_collide();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule